// File: doc/BRIEF.md
# Probe Response Accumulator

This block gathers the snoop answers that belong to one coherent transaction and turns them into a single merged answer. A probe arrives with a transaction tag. It names a set of targets. A probe from the home side targets the remote quads named in a bitmask. A probe that comes in from a remote quad targets every local processor node. The block sends the fan-out request on, loads a pending count and then takes the responses as they return. Each response is either status only or carries data from a dirty line. The block folds the status flags together and keeps the handle of the first data buffer. When the count reaches zero it issues one completion upstream.

Each transaction tag selects its own slot, so several transactions are in progress at once. The tag is the slot index. A probe whose tag is still in use is held off with back-pressure. Data buffers are not part of this block; they are named only by a small pointer handle. At most one response arrives per cycle, so at most one slot finishes per cycle, and completions leave in the order the slots finish.

Top module: `probe_resp_accum`

## Requirements
- R1: After reset, `cmp_valid` and `fan_valid` are low, and `prb_ready` is high for every tag.
- R2: A home-side probe (`prb_to_local`=0) accepted at a clock edge produces `fan_valid` for one cycle after that edge. `fan_tid` equals the probe tag and `fan_mask` equals `prb_mask`, where bit q selects remote quad q.
- R3: A probe that arrives from a remote quad (`prb_to_local`=1) ignores `prb_mask`. It fans out with `fan_to_local`=1 and a mask whose lowest NUM_LOCAL bits are set (0x0F by default), and it expects NUM_LOCAL responses.
- R4: The completion is registered. It appears for exactly one cycle after the edge that takes the response bringing the pending count (the number of set mask bits) to zero. No completion appears for any earlier response of that transaction.
- R5: The completion's `cmp_shared` and `cmp_dirty` are the OR of the shared and dirty flags of all responses in the transaction.
- R6: If any response has `rsp_has_data`=1, then `cmp_has_data`=1 and `cmp_dptr` is that response's pointer, whatever its position in the arrival order. If no response carries data, `cmp_has_data`=0.
- R7: A second data-carrying response for the same transaction sets `cmp_err`=1, and the pointer of the first data response is kept.
- R8: While a tag's slot is active, `prb_ready` is low for a probe with that tag and the probe is not accepted (no fan-out follows). The tag is accepted again once its completion has been issued.
- R9: A response for a tag with no active slot has no effect. It produces no completion and leaves no trace in a later transaction on that tag.
- R10: A probe whose target set is empty produces no fan-out. It completes one cycle after acceptance with all flags clear. If a slot finishes in the same cycle, `prb_ready` is low for it and it completes one cycle later.
- R11: Several tags may be active at once. Completions are issued in the order their last responses arrive, each carrying its own merged result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prb_valid | input | 1 | Probe offered |
| prb_ready | output | 1 | Probe can be accepted this cycle |
| prb_tid | input | TID_W | Transaction tag / slot index |
| prb_mask | input | NUM_QUADS | Remote quads to snoop (home-side probes) |
| prb_to_local | input | 1 | 1: probe came from a remote quad, broadcast locally |
| fan_valid | output | 1 | Fan-out request valid |
| fan_tid | output | TID_W | Tag of the fan-out request |
| fan_mask | output | NUM_QUADS | Targets of the fan-out request |
| fan_to_local | output | 1 | Targets are local nodes rather than remote quads |
| rsp_valid | input | 1 | Response arrives |
| rsp_tid | input | TID_W | Tag of the response |
| rsp_shared | input | 1 | Responder holds the line shared |
| rsp_dirty | input | 1 | Responder held the line dirty |
| rsp_has_data | input | 1 | Response carries data |
| rsp_dptr | input | DPTR_W | Data buffer handle of the response |
| cmp_valid | output | 1 | Merged completion valid |
| cmp_tid | output | TID_W | Tag of the completion |
| cmp_shared | output | 1 | Merged shared flag |
| cmp_dirty | output | 1 | Merged dirty flag |
| cmp_has_data | output | 1 | Some response carried data |
| cmp_dptr | output | DPTR_W | Handle of the first data response |
| cmp_err | output | 1 | More than one data response was seen |

## Verification
`prb_ready` is combinational, so the bench reads it a short delay after driving the probe and before the edge. Fan-out and completion each sit behind one register, so they are due in the cycle after the edge that takes the probe or the final response. The bench drives on the falling edge and samples one nanosecond after the next rising edge. It checks that the completion is absent after every non-final response and present after the final one. When a zero-target probe meets a finishing slot, the bench looks at the next two cycles and expects the two completions in turn.

// File: rtl/pra_pkg.sv
package pra_pkg;

   // merged status carried by each slot and by the completion
   typedef struct packed {
      logic shared;
      logic dirty;
      logic has_data;
      logic err;
   } pra_flags_t;

   localparam pra_flags_t PRA_FLAGS_CLEAR = '{shared: 1'b0, dirty: 1'b0, has_data: 1'b0, err: 1'b0};

endpackage

// File: rtl/pra_slot.sv
// One transaction slot: pending count plus folded status.
module pra_slot
   import pra_pkg::*;
#(
   parameter int CNT_W  = 4,
   parameter int DPTR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_i,
   input  logic [CNT_W-1:0]  alloc_cnt_i,
   input  logic              hit_i,
   input  logic              rsp_shared_i,
   input  logic              rsp_dirty_i,
   input  logic              rsp_has_data_i,
   input  logic [DPTR_W-1:0] rsp_dptr_i,
   output logic              busy_o,
   output logic              finish_o,
   output pra_flags_t        merged_o,
   output logic [DPTR_W-1:0] merged_dptr_o
);

   logic              busy_q;
   logic [CNT_W-1:0]  cnt_q;
   pra_flags_t        flags_q;
   logic [DPTR_W-1:0] dptr_q;
   logic              take;

   assign take = hit_i && busy_q;

   always_comb begin
      merged_o.shared   = flags_q.shared   | rsp_shared_i;
      merged_o.dirty    = flags_q.dirty    | rsp_dirty_i;
      merged_o.has_data = flags_q.has_data | rsp_has_data_i;
      merged_o.err      = flags_q.err | (flags_q.has_data & rsp_has_data_i);
      merged_dptr_o     = flags_q.has_data ? dptr_q : rsp_dptr_i;
   end

   assign finish_o = take && (cnt_q == CNT_W'(1));
   assign busy_o   = busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         cnt_q   <= '0;
         flags_q <= PRA_FLAGS_CLEAR;
         dptr_q  <= '0;
      end else if (alloc_i) begin
         busy_q  <= 1'b1;
         cnt_q   <= alloc_cnt_i;
         flags_q <= PRA_FLAGS_CLEAR;
         dptr_q  <= '0;
      end else if (take) begin
         flags_q <= merged_o;
         dptr_q  <= merged_dptr_o;
         cnt_q   <= cnt_q - CNT_W'(1);
         if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
      end
   end

endmodule

// File: rtl/pra_fanout.sv
// Target selection, pending-count computation and fan-out request.
module pra_fanout #(
   parameter int NUM_QUADS  = 8,
   parameter int NUM_LOCAL  = 4,
   parameter int TID_W      = 4,
   parameter int CNT_W      = 4,
   parameter bit REG_FANOUT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fire_i,
   input  logic [TID_W-1:0]     tid_i,
   input  logic [NUM_QUADS-1:0] mask_i,
   input  logic                 to_local_i,
   output logic [CNT_W-1:0]     exp_cnt_o,
   output logic                 fan_valid_o,
   output logic [TID_W-1:0]     fan_tid_o,
   output logic [NUM_QUADS-1:0] fan_mask_o,
   output logic                 fan_to_local_o
);

   localparam logic [NUM_QUADS-1:0] LOCAL_ALL = NUM_QUADS'((1 << NUM_LOCAL) - 1);

   logic [NUM_QUADS-1:0] eff_mask;

   assign eff_mask = to_local_i ? LOCAL_ALL : mask_i;

   always_comb begin
      exp_cnt_o = '0;
      for (int b = 0; b < NUM_QUADS; b++) begin
         exp_cnt_o = exp_cnt_o + CNT_W'(eff_mask[b]);
      end
   end

   generate
      if (REG_FANOUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               fan_valid_o    <= 1'b0;
               fan_tid_o      <= '0;
               fan_mask_o     <= '0;
               fan_to_local_o <= 1'b0;
            end else begin
               fan_valid_o <= fire_i;
               if (fire_i) begin
                  fan_tid_o      <= tid_i;
                  fan_mask_o     <= eff_mask;
                  fan_to_local_o <= to_local_i;
               end
            end
         end
      end else begin : g_comb
         assign fan_valid_o    = fire_i;
         assign fan_tid_o      = tid_i;
         assign fan_mask_o     = eff_mask;
         assign fan_to_local_o = to_local_i;
      end
   endgenerate

endmodule

// File: rtl/pra_complete.sv
// Picks the finishing slot (or an empty-target probe) and registers the completion.
module pra_complete
   import pra_pkg::*;
#(
   parameter int NUM_SLOTS = 16,
   parameter int TID_W     = 4,
   parameter int DPTR_W    = 6
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_SLOTS-1:0]              finish_i,
   input  pra_flags_t [NUM_SLOTS-1:0]        flags_i,
   input  logic [NUM_SLOTS-1:0][DPTR_W-1:0]  dptr_i,
   input  logic                              zero_i,
   input  logic [TID_W-1:0]                  zero_tid_i,
   output logic                              cmp_valid_o,
   output logic [TID_W-1:0]                  cmp_tid_o,
   output pra_flags_t                        cmp_flags_o,
   output logic [DPTR_W-1:0]                 cmp_dptr_o
);

   logic [TID_W-1:0] sel;
   logic             any;

   always_comb begin
      sel = '0;
      any = 1'b0;
      for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
         if (finish_i[i]) begin
            sel = TID_W'(i);
            any = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_valid_o <= 1'b0;
         cmp_tid_o   <= '0;
         cmp_flags_o <= PRA_FLAGS_CLEAR;
         cmp_dptr_o  <= '0;
      end else begin
         cmp_valid_o <= any || zero_i;
         if (any) begin
            cmp_tid_o   <= sel;
            cmp_flags_o <= flags_i[sel];
            cmp_dptr_o  <= dptr_i[sel];
         end else if (zero_i) begin
            cmp_tid_o   <= zero_tid_i;
            cmp_flags_o <= PRA_FLAGS_CLEAR;
            cmp_dptr_o  <= '0;
         end
      end
   end

endmodule

// File: rtl/probe_resp_accum.sv
module probe_resp_accum
   import pra_pkg::*;
#(
   parameter int NUM_SLOTS  = 16,
   parameter int NUM_QUADS  = 8,
   parameter int NUM_LOCAL  = 4,
   parameter int DPTR_W     = 6,
   parameter bit REG_FANOUT = 1'b1,
   localparam int TID_W     = $clog2(NUM_SLOTS),
   localparam int CNT_W     = $clog2(NUM_QUADS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 prb_valid,
   output logic                 prb_ready,
   input  logic [TID_W-1:0]     prb_tid,
   input  logic [NUM_QUADS-1:0] prb_mask,
   input  logic                 prb_to_local,
   output logic                 fan_valid,
   output logic [TID_W-1:0]     fan_tid,
   output logic [NUM_QUADS-1:0] fan_mask,
   output logic                 fan_to_local,
   input  logic                 rsp_valid,
   input  logic [TID_W-1:0]     rsp_tid,
   input  logic                 rsp_shared,
   input  logic                 rsp_dirty,
   input  logic                 rsp_has_data,
   input  logic [DPTR_W-1:0]    rsp_dptr,
   output logic                 cmp_valid,
   output logic [TID_W-1:0]     cmp_tid,
   output logic                 cmp_shared,
   output logic                 cmp_dirty,
   output logic                 cmp_has_data,
   output logic [DPTR_W-1:0]    cmp_dptr,
   output logic                 cmp_err
);

   // elaboration-time parameter checks
   generate
      if (NUM_SLOTS < 2 || (1 << TID_W) != NUM_SLOTS) begin : g_bad_slots
         $error("NUM_SLOTS must be a power of two, at least 2");
      end
      if (NUM_LOCAL < 1 || NUM_LOCAL > NUM_QUADS) begin : g_bad_local
         $error("NUM_LOCAL must lie in 1..NUM_QUADS");
      end
      if (DPTR_W < 1) begin : g_bad_dptr
         $error("DPTR_W must be at least 1");
      end
   endgenerate

   logic [NUM_SLOTS-1:0]             busy_vec;
   logic [NUM_SLOTS-1:0]             finish_vec;
   pra_flags_t [NUM_SLOTS-1:0]       merged_vec;
   logic [NUM_SLOTS-1:0][DPTR_W-1:0] mdptr_vec;
   logic [CNT_W-1:0]                 exp_cnt;
   logic                             zero_tgt;
   logic                             accept;
   logic                             fire;
   pra_flags_t                       cmp_flags;

   assign zero_tgt  = (exp_cnt == '0);
   assign prb_ready = !busy_vec[prb_tid] && !(zero_tgt && (|finish_vec));
   assign accept    = prb_valid && prb_ready;
   assign fire      = accept && !zero_tgt;

   pra_fanout #(
      .NUM_QUADS (NUM_QUADS),
      .NUM_LOCAL (NUM_LOCAL),
      .TID_W     (TID_W),
      .CNT_W     (CNT_W),
      .REG_FANOUT(REG_FANOUT)
   ) u_fanout (
      .clk           (clk),
      .rst_n         (rst_n),
      .fire_i        (fire),
      .tid_i         (prb_tid),
      .mask_i        (prb_mask),
      .to_local_i    (prb_to_local),
      .exp_cnt_o     (exp_cnt),
      .fan_valid_o   (fan_valid),
      .fan_tid_o     (fan_tid),
      .fan_mask_o    (fan_mask),
      .fan_to_local_o(fan_to_local)
   );

   generate
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
         logic alloc_s;
         logic hit_s;
         assign alloc_s = fire && (prb_tid == TID_W'(s));
         assign hit_s   = rsp_valid && (rsp_tid == TID_W'(s));
         pra_slot #(
            .CNT_W (CNT_W),
            .DPTR_W(DPTR_W)
         ) u_slot (
            .clk           (clk),
            .rst_n         (rst_n),
            .alloc_i       (alloc_s),
            .alloc_cnt_i   (exp_cnt),
            .hit_i         (hit_s),
            .rsp_shared_i  (rsp_shared),
            .rsp_dirty_i   (rsp_dirty),
            .rsp_has_data_i(rsp_has_data),
            .rsp_dptr_i    (rsp_dptr),
            .busy_o        (busy_vec[s]),
            .finish_o      (finish_vec[s]),
            .merged_o      (merged_vec[s]),
            .merged_dptr_o (mdptr_vec[s])
         );
      end
   endgenerate

   pra_complete #(
      .NUM_SLOTS(NUM_SLOTS),
      .TID_W    (TID_W),
      .DPTR_W   (DPTR_W)
   ) u_complete (
      .clk        (clk),
      .rst_n      (rst_n),
      .finish_i   (finish_vec),
      .flags_i    (merged_vec),
      .dptr_i     (mdptr_vec),
      .zero_i     (accept && zero_tgt),
      .zero_tid_i (prb_tid),
      .cmp_valid_o(cmp_valid),
      .cmp_tid_o  (cmp_tid),
      .cmp_flags_o(cmp_flags),
      .cmp_dptr_o (cmp_dptr)
   );

   assign cmp_shared   = cmp_flags.shared;
   assign cmp_dirty    = cmp_flags.dirty;
   assign cmp_has_data = cmp_flags.has_data;
   assign cmp_err      = cmp_flags.err;

endmodule

// File: rtl/probe_resp_accum_chk.sv
module probe_resp_accum_chk #(
   parameter int NUM_SLOTS  = 16,
   parameter int NUM_QUADS  = 8,
   parameter int NUM_LOCAL  = 4,
   parameter bit REG_FANOUT = 1'b1,
   localparam int TID_W     = $clog2(NUM_SLOTS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 prb_valid,
   input logic                 prb_ready,
   input logic [TID_W-1:0]     prb_tid,
   input logic                 fan_valid,
   input logic [TID_W-1:0]     fan_tid,
   input logic [NUM_QUADS-1:0] fan_mask,
   input logic                 fan_to_local,
   input logic                 cmp_valid,
   input logic [TID_W-1:0]     cmp_tid,
   input logic                 cmp_has_data,
   input logic                 cmp_err,
   input logic [NUM_SLOTS-1:0] busy_vec
);

   localparam logic [NUM_QUADS-1:0] LOCAL_ALL = NUM_QUADS'((1 << NUM_LOCAL) - 1);

   generate
      if (REG_FANOUT) begin : g_fan_chk
         // R2: registered fan-out follows an accepted non-empty probe
         assert_fanout_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
            fan_valid |-> $past(prb_valid && prb_ready) && (fan_tid == $past(prb_tid)));
      end
   endgenerate

   // R3: a local broadcast always targets every local node
   assert_local_broadcast_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fan_valid && fan_to_local) |-> (fan_mask == LOCAL_ALL));

   // R8: an active tag is never accepted again
   assert_busy_backpressure_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (prb_valid && busy_vec[prb_tid]) |-> !prb_ready);

   // R4: a slot is released no later than its completion appears
   assert_cmp_slot_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_valid |-> !busy_vec[cmp_tid]);

   // R7: an error report implies that data was seen
   assert_err_has_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && cmp_err) |-> cmp_has_data);

endmodule

bind probe_resp_accum probe_resp_accum_chk #(
   .NUM_SLOTS (NUM_SLOTS),
   .NUM_QUADS (NUM_QUADS),
   .NUM_LOCAL (NUM_LOCAL),
   .REG_FANOUT(REG_FANOUT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .prb_valid   (prb_valid),
   .prb_ready   (prb_ready),
   .prb_tid     (prb_tid),
   .fan_valid   (fan_valid),
   .fan_tid     (fan_tid),
   .fan_mask    (fan_mask),
   .fan_to_local(fan_to_local),
   .cmp_valid   (cmp_valid),
   .cmp_tid     (cmp_tid),
   .cmp_has_data(cmp_has_data),
   .cmp_err     (cmp_err),
   .busy_vec    (busy_vec)
);

// File: tb/tb_probe_resp_accum.sv
`timescale 1ns/1ps
module tb_probe_resp_accum;

   localparam int TID_W  = 4;
   localparam int NQ     = 8;
   localparam int DPTR_W = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              prb_valid = 1'b0;
   logic              prb_ready;
   logic [TID_W-1:0]  prb_tid = '0;
   logic [NQ-1:0]     prb_mask = '0;
   logic              prb_to_local = 1'b0;
   logic              fan_valid;
   logic [TID_W-1:0]  fan_tid;
   logic [NQ-1:0]     fan_mask;
   logic              fan_to_local;
   logic              rsp_valid = 1'b0;
   logic [TID_W-1:0]  rsp_tid = '0;
   logic              rsp_shared = 1'b0;
   logic              rsp_dirty = 1'b0;
   logic              rsp_has_data = 1'b0;
   logic [DPTR_W-1:0] rsp_dptr = '0;
   logic              cmp_valid;
   logic [TID_W-1:0]  cmp_tid;
   logic              cmp_shared;
   logic              cmp_dirty;
   logic              cmp_has_data;
   logic [DPTR_W-1:0] cmp_dptr;
   logic              cmp_err;

   int total = 0;
   int bad   = 0;
   bit ready_seen;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   probe_resp_accum dut (
      .clk(clk), .rst_n(rst_n),
      .prb_valid(prb_valid), .prb_ready(prb_ready), .prb_tid(prb_tid),
      .prb_mask(prb_mask), .prb_to_local(prb_to_local),
      .fan_valid(fan_valid), .fan_tid(fan_tid), .fan_mask(fan_mask),
      .fan_to_local(fan_to_local),
      .rsp_valid(rsp_valid), .rsp_tid(rsp_tid), .rsp_shared(rsp_shared),
      .rsp_dirty(rsp_dirty), .rsp_has_data(rsp_has_data), .rsp_dptr(rsp_dptr),
      .cmp_valid(cmp_valid), .cmp_tid(cmp_tid), .cmp_shared(cmp_shared),
      .cmp_dirty(cmp_dirty), .cmp_has_data(cmp_has_data), .cmp_dptr(cmp_dptr),
      .cmp_err(cmp_err)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // drive on falling edge, note ready before the edge, sample 1 ns after the rising edge
   task automatic step(input bit pv, input int ptid, input int pmask, input bit ploc,
                       input bit rv, input int rtid, input bit rsh, input bit rdy,
                       input bit rdat, input int rdp);
      @(negedge clk);
      prb_valid = pv; prb_tid = TID_W'(ptid); prb_mask = NQ'(pmask); prb_to_local = ploc;
      rsp_valid = rv; rsp_tid = TID_W'(rtid); rsp_shared = rsh; rsp_dirty = rdy;
      rsp_has_data = rdat; rsp_dptr = DPTR_W'(rdp);
      #1 ready_seen = prb_ready;
      @(posedge clk);
      #1;
      prb_valid = 1'b0; rsp_valid = 1'b0;
   endtask

   task automatic probe(input int tid, input int mask, input bit loc);
      step(1'b1, tid, mask, loc, 1'b0, 0, 1'b0, 1'b0, 1'b0, 0);
   endtask

   task automatic resp(input int tid, input bit sh, input bit dy, input bit dat, input int dp);
      step(1'b0, 0, 0, 1'b0, 1'b1, tid, sh, dy, dat, dp);
   endtask

   task automatic idle();
      step(1'b0, 0, 0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b0, 0);
   endtask

   task automatic expect_cmp(input string req, input int tid, input bit sh, input bit dy,
                             input bit dat, input int dp, input bit er);
      check(req, "cmp_valid", cmp_valid, 1);
      check(req, "cmp_tid", cmp_tid, tid);
      check(req, "cmp_shared", cmp_shared, sh);
      check(req, "cmp_dirty", cmp_dirty, dy);
      check(req, "cmp_has_data", cmp_has_data, dat);
      if (dat) check(req, "cmp_dptr", cmp_dptr, dp);
      check(req, "cmp_err", cmp_err, er);
   endtask

   task automatic t_reset();
      check("R1", "cmp_valid", cmp_valid, 0);
      check("R1", "fan_valid", fan_valid, 0);
      for (int t = 0; t < 16; t++) begin
         @(negedge clk); prb_tid = TID_W'(t); #1;
         check("R1", "prb_ready", prb_ready, 1);
      end
   endtask

   task automatic t_home();
      probe(3, 'h26, 1'b0);
      check("R2", "fan_valid", fan_valid, 1);
      check("R2", "fan_tid", fan_tid, 3);
      check("R2", "fan_mask", fan_mask, 'h26);
      check("R2", "fan_to_local", fan_to_local, 0);
      resp(3, 1'b1, 1'b0, 1'b0, 0);
      check("R2", "fan_valid drops", fan_valid, 0);
      check("R4", "no early cmp 1", cmp_valid, 0);
      resp(3, 1'b0, 1'b0, 1'b0, 0);
      check("R4", "no early cmp 2", cmp_valid, 0);
      resp(3, 1'b0, 1'b1, 1'b1, 9);
      expect_cmp("R5", 3, 1'b1, 1'b1, 1'b1, 9, 1'b0);
      idle();
      check("R4", "cmp one cycle", cmp_valid, 0);
   endtask

   task automatic t_remote();
      probe(5, 'hFF, 1'b1);
      check("R3", "fan_valid", fan_valid, 1);
      check("R3", "fan_mask", fan_mask, 'h0F);
      check("R3", "fan_to_local", fan_to_local, 1);
      resp(5, 1'b0, 1'b1, 1'b1, 'h21);
      check("R3", "no cmp after 1", cmp_valid, 0);
      resp(5, 1'b0, 1'b0, 1'b0, 0);
      resp(5, 1'b0, 1'b0, 1'b0, 0);
      check("R3", "no cmp after 3", cmp_valid, 0);
      resp(5, 1'b0, 1'b0, 1'b0, 'h3);
      expect_cmp("R6", 5, 1'b0, 1'b1, 1'b1, 'h21, 1'b0);
   endtask

   task automatic t_err();
      probe(7, 'h03, 1'b0);
      resp(7, 1'b0, 1'b1, 1'b1, 4);
      resp(7, 1'b0, 1'b1, 1'b1, 5);
      expect_cmp("R7", 7, 1'b0, 1'b1, 1'b1, 4, 1'b1);
   endtask

   task automatic t_backpressure();
      probe(2, 'h01, 1'b0);
      probe(2, 'h02, 1'b0);
      check("R8", "ready low on busy tag", ready_seen, 0);
      check("R8", "no fan-out when held", fan_valid, 0);
      resp(2, 1'b1, 1'b0, 1'b0, 0);
      expect_cmp("R8", 2, 1'b1, 1'b0, 1'b0, 0, 1'b0);
      probe(2, 'h02, 1'b0);
      check("R8", "ready after free", ready_seen, 1);
      check("R8", "fan mask reaccepted", fan_mask, 'h02);
      resp(2, 1'b0, 1'b0, 1'b0, 0);
      expect_cmp("R8", 2, 1'b0, 1'b0, 1'b0, 0, 1'b0);
   endtask

   task automatic t_idle_rsp();
      resp(9, 1'b1, 1'b1, 1'b1, 7);
      check("R9", "no cmp for idle tag", cmp_valid, 0);
      probe(9, 'h01, 1'b0);
      resp(9, 1'b0, 1'b0, 1'b0, 0);
      expect_cmp("R9", 9, 1'b0, 1'b0, 1'b0, 0, 1'b0);
   endtask

   task automatic t_zero();
      probe(11, 'h00, 1'b0);
      check("R10", "no fan-out", fan_valid, 0);
      expect_cmp("R10", 11, 1'b0, 1'b0, 1'b0, 0, 1'b0);
      probe(12, 'h01, 1'b0);
      step(1'b1, 13, 'h00, 1'b0, 1'b1, 12, 1'b1, 1'b0, 1'b0, 0);
      check("R10", "ready low on collision", ready_seen, 0);
      expect_cmp("R10", 12, 1'b1, 1'b0, 1'b0, 0, 1'b0);
      probe(13, 'h00, 1'b0);
      check("R10", "ready after collision", ready_seen, 1);
      expect_cmp("R10", 13, 1'b0, 1'b0, 1'b0, 0, 1'b0);
   endtask

   task automatic t_concurrent();
      probe(0, 'h03, 1'b0);
      probe(1, 'h01, 1'b0);
      probe(4, 'h00, 1'b1);
      resp(1, 1'b1, 1'b0, 1'b0, 0);
      expect_cmp("R11", 1, 1'b1, 1'b0, 1'b0, 0, 1'b0);
      resp(0, 1'b0, 1'b0, 1'b0, 0);
      check("R11", "no cmp mid", cmp_valid, 0);
      resp(4, 1'b1, 1'b0, 1'b0, 0);
      resp(4, 1'b0, 1'b0, 1'b1, 17);
      resp(4, 1'b0, 1'b0, 1'b0, 0);
      check("R11", "no cmp mid 2", cmp_valid, 0);
      resp(0, 1'b0, 1'b1, 1'b0, 0);
      expect_cmp("R11", 0, 1'b0, 1'b1, 1'b0, 0, 1'b0);
      resp(4, 1'b0, 1'b0, 1'b0, 0);
      expect_cmp("R11", 4, 1'b1, 1'b0, 1'b1, 17, 1'b0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_home();
      t_remote();
      t_err();
      t_backpressure();
      t_idle_rsp();
      t_zero();
      t_concurrent();
      idle();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule